// File: doc/BRIEF.md
# Serial Attenuator Shift-Register Driver

This block sends 8-bit settings words to four external serial-in/parallel-out shift registers. Each register sits on a mezzanine channel and holds a 6-bit step attenuator code and an RF switch enable. A caller presents a channel index (0 to 3) and a settings word, and pulses a start strobe. The block reorders the attenuation bits so that the 0.5 dB stage comes first in the register. It then shifts the resulting 8-bit frame out on the addressed lane, most significant bit first, and raises that lane's storage latch for a short pulse. The register's parallel outputs therefore change in one step. Software addresses these lanes as extended-write addresses 0x0C to 0x0F, so lane n corresponds to address 0x0C + n.

The shift clock runs at one bit per `BIT_DIV` core cycles. The default is 32, which is slow enough to give the external register its 125 ns data-to-clock setup time. Data changes at the start of each bit period, and the shift clock rises halfway through it. A shared output-enable level, taken from the configuration register, is registered and driven to all four registers together.

When reset is released, the block loads every channel in turn, 0 to 3, with the power-on setting: code 63 (31.5 dB) and the switch off. During that time it reports busy. A start request that arrives while the block is busy is dropped.

Top module: `sr_atten_driver`

## Requirements
- R1: `chan_i` selects lane n (0 to 3) for a transfer. Only lane n's `ser_data_o`, `shift_clk_o` and `latch_o` bits move. All other lanes stay low, and every lane is low while the block is not busy.
- R2: A transfer shifts exactly 8 bits, most significant first, with one shift-clock rising edge per bit. After the latch, an external register that shifts toward Q7 holds the frame: bit 7 = 0, bit 6 = `word_i[6]` (switch enable), and bits 5:0 = the reordered attenuation code.
- R3: The attenuation code in `word_i[5:0]` is bit-reversed. Input bit i lands in frame bit 5-i.
- R4: `word_i[7]` has no effect. Frame bit 7 is always 0.
- R5: Each bit lasts `BIT_DIV` cycles. Serial data is stable for at least `BIT_DIV/2` cycles before each shift-clock rising edge.
- R6: After the eighth bit, the addressed lane's latch is high for exactly `LATCH_CYC` cycles. No shift clock is high while a latch is high.
- R7: A start request while `busy_o` is high is ignored. It changes no lane and does not extend the busy time.
- R8: Busy rises in the cycle after an accepted start and stays high for 8*`BIT_DIV` + `LATCH_CYC` cycles. It falls only after a latch cycle.
- R9: Busy is high during and after reset until the block has loaded channels 0 to 3, in order, with frame 0x3F (code 63, switch off).
- R10: `oe_o` equals `oe_i` delayed by one clock and is low in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| chan_i | input | 2 | Channel index 0 to 3 |
| word_i | input | 8 | Settings word: [5:0] code, [6] switch, [7] ignored |
| oe_i | input | 1 | Shared output-enable level from the configuration register |
| ser_data_o | output | 4 | Per-lane serial data |
| shift_clk_o | output | 4 | Per-lane shift clock |
| latch_o | output | 4 | Per-lane storage latch |
| oe_o | output | 1 | Registered output enable, common to all lanes |
| busy_o | output | 1 | Transfer or power-on load in progress |

## Verification
The assertions assume that reset is held low from time zero, and that `start_i` lasts one cycle with `chan_i` and `word_i` valid in that cycle. They also assume that `BIT_DIV` is even and at least 2. The bench drives every input on falling clock edges only, so inputs are always settled when the design samples them. It also uses a small even divider, so that every channel can be swept with all 256 words.

// File: rtl/sra_pkg.sv
// Shared types for the serial attenuator driver.
// Assumes nothing beyond a synchronous clock domain.
package sra_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } drv_state_t;

endpackage

// File: rtl/sra_frame_fmt.sv
// Builds the 8-bit serial frame from a settings word: the attenuation
// field is bit-reversed, the switch bit is kept, and the top bit is forced low.
// Assumes the word is ATT_W + 2 bits wide.
module sra_frame_fmt #(
    parameter int ATT_W = 6,
    localparam int WORD_W = ATT_W + 2
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] frame_o
);

    // Reverse the attenuation field so its lowest bit drives the first stage.
    for (genvar g = 0; g < ATT_W; g++) begin : g_rev
        assign frame_o[ATT_W-1-g] = word_i[g];
    end

    // Switch bit stays in place; the spare top bit is sent as zero.
    assign frame_o[ATT_W]   = word_i[ATT_W];
    assign frame_o[ATT_W+1] = 1'b0;

endmodule

// File: rtl/sra_bit_timer.sv
// Times the serial bits: each bit lasts BIT_DIV cycles, and the shift clock
// is high in the second half of the bit. Counters clear whenever run_i is low.
// Assumes BIT_DIV is even and at least 2.
module sra_bit_timer #(
    parameter int BIT_DIV = 32,
    parameter int NBITS   = 8,
    localparam int DW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1,
    localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    output logic [BW-1:0] bit_idx_o,
    output logic          sclk_o,
    output logic          frame_end_o
);

    localparam logic [DW-1:0] LAST_DIV = DW'(BIT_DIV - 1);
    localparam logic [DW-1:0] HALF     = DW'(BIT_DIV / 2);
    localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

    logic [DW-1:0] div_q;
    logic [BW-1:0] bit_q;

    // Advance the divider and the bit index while a frame is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            div_q <= '0;
            bit_q <= '0;
        end else if (div_q == LAST_DIV) begin
            div_q <= '0;
            bit_q <= bit_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Shift clock high in the second half of each bit period.
    always_comb begin
        sclk_o      = run_i && (div_q >= HALF);
        frame_end_o = run_i && (div_q == LAST_DIV) && (bit_q == LAST_BIT);
        bit_idx_o   = bit_q;
    end

endmodule

// File: rtl/sra_lane_demux.sv
// Routes the single serial engine onto the addressed lane and holds every
// other lane low. Assumes sel_i stays constant while active_i is high.
module sra_lane_demux #(
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [CH_W-1:0]   sel_i,
    input  logic              active_i,
    input  logic              data_i,
    input  logic              sclk_i,
    input  logic              latch_i,
    output logic [NUM_CH-1:0] data_o,
    output logic [NUM_CH-1:0] sclk_o,
    output logic [NUM_CH-1:0] latch_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        logic hit;
        // Lane g is live only when addressed during a transfer.
        always_comb begin
            hit        = active_i && (sel_i == CH_W'(g));
            data_o[g]  = hit && data_i;
            sclk_o[g]  = hit && sclk_i;
            latch_o[g] = hit && latch_i;
        end
    end

endmodule

// File: rtl/sr_atten_driver.sv
// Drives four external serial-in/parallel-out attenuator registers.
// It accepts one settings word per start strobe, shifts the reordered frame
// MSB first, then pulses that lane's latch. After reset, it loads every lane
// with the power-on frame. The output enable is shared by all lanes.
// Assumes start_i is a one-cycle strobe with chan_i and word_i valid with it.
module sr_atten_driver
    import sra_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ATT_W     = 6,
    parameter int BIT_DIV   = 32,
    parameter int LATCH_CYC = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int WORD_W = ATT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              oe_i,
    output logic [NUM_CH-1:0] ser_data_o,
    output logic [NUM_CH-1:0] shift_clk_o,
    output logic [NUM_CH-1:0] latch_o,
    output logic              oe_o,
    output logic              busy_o
);

    localparam int BW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int LC_W = (LATCH_CYC > 1) ? $clog2(LATCH_CYC) : 1;
    localparam logic [BW-1:0]     LAST_BIT  = BW'(WORD_W - 1);
    localparam logic [LC_W-1:0]   LAST_LAT  = LC_W'(LATCH_CYC - 1);
    localparam logic [CH_W-1:0]   LAST_CH   = CH_W'(NUM_CH - 1);
    // Power-on frame: full attenuation, switch off, spare bit low.
    localparam logic [WORD_W-1:0] INIT_FRAME = WORD_W'((1 << ATT_W) - 1);

    drv_state_t        state_q;
    logic              init_pend_q;
    logic [CH_W-1:0]   init_ch_q;
    logic [CH_W-1:0]   cur_ch_q;
    logic [WORD_W-1:0] cur_frame_q;
    logic [LC_W-1:0]   lat_cnt_q;
    logic              oe_q;

    logic [WORD_W-1:0] fmt_frame;
    logic [BW-1:0]     bit_idx;
    logic              sclk;
    logic              frame_end;
    logic              ser_bit;

    sra_frame_fmt #(.ATT_W(ATT_W)) u_fmt (
        .word_i  (word_i),
        .frame_o (fmt_frame)
    );

    sra_bit_timer #(.BIT_DIV(BIT_DIV), .NBITS(WORD_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (state_q == ST_SHIFT),
        .bit_idx_o   (bit_idx),
        .sclk_o      (sclk),
        .frame_end_o (frame_end)
    );

    // Main sequencer: power-on loads, start acceptance, shift and latch phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            init_pend_q <= 1'b1;
            init_ch_q   <= '0;
            cur_ch_q    <= '0;
            cur_frame_q <= '0;
            lat_cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (init_pend_q) begin
                        cur_ch_q    <= init_ch_q;
                        cur_frame_q <= INIT_FRAME;
                        state_q     <= ST_SHIFT;
                        init_ch_q   <= init_ch_q + 1'b1;
                        if (init_ch_q == LAST_CH) begin
                            init_pend_q <= 1'b0;
                        end
                    end else if (start_i) begin
                        cur_ch_q    <= chan_i;
                        cur_frame_q <= fmt_frame;
                        state_q     <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (frame_end) begin
                        state_q   <= ST_LATCH;
                        lat_cnt_q <= '0;
                    end
                end
                ST_LATCH: begin
                    if (lat_cnt_q == LAST_LAT) begin
                        state_q <= ST_IDLE;
                    end else begin
                        lat_cnt_q <= lat_cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register the shared output-enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= oe_i;
        end
    end

    // Pick the current frame bit, MSB first, only during the shift phase.
    always_comb begin
        ser_bit = (state_q == ST_SHIFT) && cur_frame_q[LAST_BIT - bit_idx];
    end

    sra_lane_demux #(.NUM_CH(NUM_CH)) u_demux (
        .sel_i    (cur_ch_q),
        .active_i (state_q != ST_IDLE),
        .data_i   (ser_bit),
        .sclk_i   (sclk),
        .latch_i  (state_q == ST_LATCH),
        .data_o   (ser_data_o),
        .sclk_o   (shift_clk_o),
        .latch_o  (latch_o)
    );

    // Busy covers any transfer and any power-on load still pending.
    always_comb begin
        busy_o = (state_q != ST_IDLE) || init_pend_q;
        oe_o   = oe_q;
    end

endmodule

// File: rtl/sra_checker.sv
// Property checker for the serial attenuator driver, bound to the top.
// Assumes reset is asserted from time zero.
module sra_checker #(
    parameter int NUM_CH  = 4,
    parameter int BIT_DIV = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic [NUM_CH-1:0] ser_data_o,
    input logic [NUM_CH-1:0] shift_clk_o,
    input logic [NUM_CH-1:0] latch_o,
    input logic              oe_i,
    input logic              oe_o
);

    localparam int CW = $clog2(BIT_DIV + 2) + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam logic [CW-1:0] NEED = CW'(BIT_DIV / 2 - 1);

    logic [NUM_CH-1:0] prev_data_q;
    logic [CW-1:0]     stable_q;
    logic              past_ok_q;

    // Count the samples for which the serial data has held its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_data_q <= '0;
            stable_q    <= '0;
            past_ok_q   <= 1'b0;
        end else begin
            prev_data_q <= ser_data_o;
            past_ok_q   <= 1'b1;
            if (ser_data_o != prev_data_q) begin
                stable_q <= '0;
            end else if (stable_q != CMAX) begin
                stable_q <= stable_q + 1'b1;
            end
        end
    end

    AST_LANE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(shift_clk_o) && $onehot0(latch_o)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (shift_clk_o == '0 && latch_o == '0 && ser_data_o == '0)); // R1

    AST_SETUP_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|shift_clk_o) |-> (ser_data_o == prev_data_q && stable_q >= NEED)); // R5

    AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|latch_o) |-> (shift_clk_o == '0)); // R6

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(|latch_o)); // R8

    AST_LATCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|latch_o) |-> busy_o); // R8

    AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (oe_o == $past(oe_i))); // R10

endmodule

bind sr_atten_driver sra_checker #(.NUM_CH(NUM_CH), .BIT_DIV(BIT_DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .ser_data_o  (ser_data_o),
    .shift_clk_o (shift_clk_o),
    .latch_o     (latch_o),
    .oe_i        (oe_i),
    .oe_o        (oe_o)
);

// File: tb/sim_sr_atten_driver.sv
// Bench: models four external shift registers and sweeps every word on every lane.
module sim_sr_atten_driver;

    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 4;
    localparam int LCYC = 2;
    localparam int HALF = DIV / 2;
    localparam int XFER_CYC = 8 * DIV + LCYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] chan_i = '0;
    logic [7:0] word_i = '0;
    logic       oe_i = 1'b0;
    logic [3:0] ser_data_o, shift_clk_o, latch_o;
    logic       oe_o, busy_o;

    int checks = 0;
    int errors = 0;

    sr_atten_driver #(.BIT_DIV(DIV), .LATCH_CYC(LCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .word_i(word_i), .oe_i(oe_i), .ser_data_o(ser_data_o),
        .shift_clk_o(shift_clk_o), .latch_o(latch_o), .oe_o(oe_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // External register models and timing monitors, updated on falling edges.
    logic [7:0] sr_m  [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
    logic [7:0] par_m [4] = '{8'hAA, 8'hAA, 8'hAA, 8'hAA};
    int rises [4] = '{0, 0, 0, 0};
    int lat_n [4] = '{0, 0, 0, 0};
    int stab  [4] = '{0, 0, 0, 0};
    int setup_viol = 0;
    logic [3:0] sclk_p = '0, lat_p = '0, dat_p = '0;

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (shift_clk_o[i] && !sclk_p[i]) begin
                rises[i]++;
                if (stab[i] < HALF) setup_viol++;
                sr_m[i] = {sr_m[i][6:0], ser_data_o[i]};
            end
            if (latch_o[i] && !lat_p[i]) par_m[i] = sr_m[i];
            if (latch_o[i]) lat_n[i]++;
            if (ser_data_o[i] != dat_p[i]) stab[i] = 1;
            else if (stab[i] < 1000) stab[i]++;
        end
        sclk_p = shift_clk_o;
        lat_p  = latch_o;
        dat_p  = ser_data_o;
    end

    function automatic logic [7:0] exp_frame(input logic [7:0] w);
        logic [7:0] f;
        f[7] = 1'b0;
        f[6] = w[6];
        for (int i = 0; i < 6; i++) f[5-i] = w[i];
        return f;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Run one transfer; optionally fire an extra start mid-way (must be ignored).
    task automatic xfer(input int ch, input logic [7:0] w, input bit poke,
                        input int pch, input logic [7:0] pw);
        logic [7:0] par0 [4];
        int r0 [4];
        int l0 [4];
        int v0, nb;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            par0[i] = par_m[i]; r0[i] = rises[i]; l0[i] = lat_n[i];
        end
        v0 = setup_viol;
        start_i = 1'b1; chan_i = 2'(ch); word_i = w;
        @(negedge clk);
        start_i = 1'b0;
        nb = 0;
        while (busy_o) begin
            nb++;
            if (poke && nb == 10) begin
                start_i = 1'b1; chan_i = 2'(pch); word_i = pw;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        @(negedge clk);
        chk(par_m[ch] == exp_frame(w), w[7] ? "R4 frame with bit7 set" : "R2/R3 frame",
            par_m[ch], exp_frame(w));
        chk(rises[ch] - r0[ch] == 8, "R2 shift clock count", rises[ch] - r0[ch], 8);
        chk(lat_n[ch] - l0[ch] == LCYC, "R6 latch width", lat_n[ch] - l0[ch], LCYC);
        chk(setup_viol == v0, "R5 setup time", setup_viol - v0, 0);
        chk(nb == XFER_CYC, poke ? "R7 busy length with ignored start" : "R8 busy length",
            nb, XFER_CYC);
        for (int i = 0; i < 4; i++) begin
            if (i != ch) begin
                chk(par_m[i] == par0[i] && rises[i] == r0[i] && lat_n[i] == l0[i],
                    poke ? "R7 other lane untouched" : "R1 other lane untouched",
                    par_m[i], par0[i]);
            end
        end
    endtask

    // Watchdog: a hang counts as a failure and still reports the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nb;
        oe_i = 1'b1;
        repeat (3) @(negedge clk);
        // Reset state.
        chk(shift_clk_o == 0 && latch_o == 0 && ser_data_o == 0, "R1 lanes quiet in reset",
            {shift_clk_o, latch_o}, 0);
        chk(oe_o == 1'b0, "R10 oe low in reset", oe_o, 0);
        chk(busy_o == 1'b1, "R9 busy in reset", busy_o, 1);
        rst_n = 1'b1;
        // Power-on load: a start during it must be ignored (R9, R7).
        nb = 0;
        while (busy_o) begin
            nb++;
            start_i = (nb == 5);
            chan_i = 2'd2; word_i = 8'h00;
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R7 start during power-on load ignored", busy_o, 0);
        chk(nb == 4 * (XFER_CYC + 1), "R9 power-on load length", nb, 4 * (XFER_CYC + 1));
        for (int i = 0; i < 4; i++) begin
            chk(par_m[i] == 8'h3F, "R9 power-on frame", par_m[i], 8'h3F);
            chk(rises[i] == 8, "R9 power-on shift count", rises[i], 8);
        end
        chk(setup_viol == 0, "R5 setup during power-on load", setup_viol, 0);
        // Output enable follows with one cycle of delay.
        chk(oe_o == 1'b1, "R10 oe high", oe_o, 1);
        oe_i = 1'b0;
        @(negedge clk);
        chk(oe_o == 1'b0, "R10 oe low", oe_o, 0);
        oe_i = 1'b1;
        @(negedge clk);
        chk(oe_o == 1'b1, "R10 oe high again", oe_o, 1);
        // Exhaustive sweep: every lane, every word.
        for (int ch = 0; ch < 4; ch++) begin
            for (int w = 0; w < 256; w++) begin
                xfer(ch, 8'(w), 1'b0, 0, 8'h00);
            end
        end
        // Start while busy: second request must be dropped.
        xfer(0, 8'h15, 1'b1, 1, 8'h2A);
        xfer(3, 8'h7F, 1'b1, 2, 8'h01);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule